// File: doc/BRIEF.md
# PLL Reconfiguration Clock Controller

This block is the control state machine that sits behind a small memory-mapped PLL setup register. A software write that selects a PLL mode starts a reconfiguration phase. During that phase the block forces the output divider to its largest value, divide-by-16, so that the clock tree never sees an out-of-range frequency while the PLL hunts. It reports a lock flag and an emergency flag, and it returns all ones in the divider field of the register until the PLL has relocked. Lock indications come from an analog model and are brought into the clock domain through two flip-flops.

The block also sequences sleep. While asleep the VCO enable is dropped and the clock select is parked. On a wake event, the block picks the next clock source from the stored control mode and from a flag that says whether the real-time clock runs from the main oscillator. Sleep entered while a PLL reconfiguration is still pending leaves the block in a sticky emergency state. In that state it runs the PLL output divided by 16 until reset, or until a fresh PLL-mode write completes with lock. A sleep-permitted status bit lets software test whether sleep entry is safe.

Register layout (6 bits): bits [1:0] are the control mode and bits [5:2] are the divider code D, where the divider is K = D+1. The mode encodings are: 00 bypass with VCO off, 01 bypass with VCO on, 10 and 11 PLL modes.

Top module: `pll_clk_ctrl`

## Requirements
- R1: After reset the register reads 0, the lock and emergency flags are 0, vco_en is 0, clk_sel is 00 (oscillator) and div_k is 1.
- R2: A write with bit 1 set (PLL mode 10 or 11), accepted in run, relock or emergency, takes effect from the next cycle. From then on div_k is 16, the lock flag is 0, the divider field reads 0xF and clk_sel is 01 (PLL).
- R3: A reconfiguration completes when the synchronised PLL lock has been seen low and then high. This happens on the third rising clock edge after pll_lock_a rises. The lock flag then reads 1, div_k is D+1 and the field reads back D.
- R4: A bypass-mode write (bit 1 clear) in run state does not start a reconfiguration. The lock flag is unchanged, div_k becomes D+1 at once and clk_sel is 00.
- R5: sleep_ok is 1 only when the synchronised oscillator lock is 1, the lock flag is 1 and the divider field does not read 0xF.
- R6: vco_en is 0 in sleep and in the wait for the oscillator after wake-up. Otherwise it is 1 in the PLL modes, in mode 01, during relock and in emergency, and 0 in running mode 00.
- R7: A wake event with mode 00, rtc_on_main = 1 and nothing pending returns the block to run on the oscillator on the next cycle, without waiting for oscillator lock.
- R8: Any other wake with nothing pending waits for synchronised oscillator lock, with clk_sel 10 (stopped). A bypass mode then resumes on the oscillator. A PLL mode enters a relock phase, as in R2.
- R9: A wake after sleep was entered with a PLL-mode reconfiguration pending enters emergency: the emergency flag is 1, div_k is 16, the field reads 0xF and clk_sel is 01. This holds while both locks are high.
- R10: Emergency clears only by reset or by a PLL-mode write that then completes as in R3. A bypass write in emergency has no effect.
- R11: Writes are ignored in sleep and while waiting for the oscillator. sleep_req is ignored while waiting for the oscillator.
- R12: clk_sel is 00 for the oscillator, 01 for the PLL output and 10 for stopped (sleep and wake wait).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 6 | Register write data |
| cfg_rdata | output | 6 | Register read data |
| osc_lock_a | input | 1 | Oscillator lock from the analog model (asynchronous) |
| pll_lock_a | input | 1 | PLL lock from the analog model (asynchronous) |
| sleep_req | input | 1 | Request to enter sleep |
| wake_evt | input | 1 | Wake-up event |
| rtc_on_main | input | 1 | Real-time clock runs from the main oscillator |
| div_k | output | 5 | Effective output divider K |
| vco_en | output | 1 | VCO enable |
| clk_sel | output | 2 | Clock source select |
| pll_locked | output | 1 | Lock status flag |
| emerg | output | 1 | Emergency status flag |
| osc_locked | output | 1 | Synchronised oscillator lock |
| sleep_ok | output | 1 | Sleep entry is safe |

## Verification
A wrong state is visible at the ports within one cycle. A missed relock entry shows as div_k other than 16 with the field not reading 0xF. A missed emergency shows as a clean divider after a wake with a reconfiguration pending. A lost sleep shows as vco_en or a clk_sel other than 10. Lock completion is timed to the exact edge, so an extra or missing synchroniser stage moves the flag by one cycle and is caught. The emergency is held for many cycles with both locks high, which proves it is sticky.

// File: rtl/pll_clk_ctrl.sv
module pll_clk_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ODIV_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ODIV_W+1:0] cfg_wdata,
  output logic [ODIV_W+1:0] cfg_rdata,
  input  logic              osc_lock_a,
  input  logic              pll_lock_a,
  input  logic              sleep_req,
  input  logic              wake_evt,
  input  logic              rtc_on_main,
  output logic [ODIV_W:0]   div_k,
  output logic              vco_en,
  output logic [1:0]        clk_sel,
  output logic              pll_locked,
  output logic              emerg,
  output logic              osc_locked,
  output logic              sleep_ok
);
  localparam int REG_W = ODIV_W + 2;
  localparam logic [ODIV_W-1:0] ODIV_MAX = '1;
  localparam logic [ODIV_W:0]   K_SAFE   = (ODIV_W+1)'(2**ODIV_W);
  localparam logic [1:0] SEL_OSC = 2'b00, SEL_PLL = 2'b01, SEL_OFF = 2'b10;

  typedef enum logic [2:0] {ST_RUN, ST_RELOCK, ST_SLEEP, ST_WAKE, ST_EMERG} st_t;

  st_t state;
  logic [SYNC_STAGES-1:0] osc_sh, pll_sh;
  logic [1:0]        mode_q;
  logic [ODIV_W-1:0] odiv_q;
  logic lock_q, emerg_q, pend_q, seen_low_q;

  wire osc_s = osc_sh[SYNC_STAGES-1];
  wire pll_s = pll_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      osc_sh <= '0;
      pll_sh <= '0;
    end else begin
      osc_sh <= {osc_sh[SYNC_STAGES-2:0], osc_lock_a};
      pll_sh <= {pll_sh[SYNC_STAGES-2:0], pll_lock_a};
    end

  wire active  = (state == ST_RUN) || (state == ST_RELOCK) || (state == ST_EMERG);
  wire wr_ok   = cfg_wr && active;
  wire wr_pll  = wr_ok && cfg_wdata[1];
  wire wr_byp  = wr_ok && !cfg_wdata[1] && !emerg_q && (state != ST_EMERG);
  wire forced  = (state == ST_RELOCK) || (state == ST_EMERG);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_RUN;
      mode_q     <= 2'b00;
      odiv_q     <= '0;
      lock_q     <= 1'b0;
      emerg_q    <= 1'b0;
      pend_q     <= 1'b0;
      seen_low_q <= 1'b0;
    end else begin
      case (state)
        ST_RUN, ST_RELOCK, ST_EMERG: begin
          if (wr_pll) begin
            mode_q     <= cfg_wdata[1:0];
            odiv_q     <= cfg_wdata[REG_W-1:2];
            lock_q     <= 1'b0;
            pend_q     <= 1'b1;
            seen_low_q <= 1'b0;
            state      <= ST_RELOCK;
          end else if (wr_byp) begin
            mode_q <= cfg_wdata[1:0];
            odiv_q <= cfg_wdata[REG_W-1:2];
            pend_q <= 1'b0;
            state  <= ST_RUN;
          end else if (sleep_req) begin
            state <= ST_SLEEP;
          end else if (state == ST_RELOCK) begin
            if (!pll_s) seen_low_q <= 1'b1;
            else if (seen_low_q) begin
              lock_q  <= 1'b1;
              pend_q  <= 1'b0;
              emerg_q <= 1'b0;
              state   <= ST_RUN;
            end
          end
        end
        ST_SLEEP:
          if (wake_evt) begin
            if (pend_q || emerg_q) begin
              emerg_q <= 1'b1;
              lock_q  <= 1'b0;
              pend_q  <= 1'b0;
              state   <= ST_EMERG;
            end else if (mode_q == 2'b00 && rtc_on_main) state <= ST_RUN;
            else state <= ST_WAKE;
          end
        ST_WAKE:
          if (osc_s) begin
            if (mode_q[1]) begin
              lock_q     <= 1'b0;
              seen_low_q <= 1'b0;
              state      <= ST_RELOCK;
            end else state <= ST_RUN;
          end
        default: state <= ST_RUN;
      endcase
    end

  wire [ODIV_W-1:0] rd_odiv = forced ? ODIV_MAX : odiv_q;

  assign cfg_rdata  = {rd_odiv, mode_q};
  assign div_k      = forced ? K_SAFE : ({1'b0, odiv_q} + 1'b1);
  assign vco_en     = forced || (state == ST_RUN && mode_q != 2'b00);
  assign clk_sel    = forced ? SEL_PLL :
                      (state == ST_RUN) ? (mode_q[1] ? SEL_PLL : SEL_OSC) : SEL_OFF;
  assign pll_locked = lock_q;
  assign emerg      = emerg_q;
  assign osc_locked = osc_s;
  assign sleep_ok   = osc_s && lock_q && (rd_odiv != ODIV_MAX);

  p_reloc_div16_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pll |=> (div_k == K_SAFE) && !pll_locked && (cfg_rdata[REG_W-1:2] == ODIV_MAX));

  p_bypass_keep_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byp && state == ST_RUN) |=> (pll_locked == $past(pll_locked)) && (state == ST_RUN));

  p_lock_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> !emerg_q && (state == ST_RUN) && (clk_sel == SEL_PLL || clk_sel == SEL_OSC));

  p_sleep_vco_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |-> !vco_en && (clk_sel == SEL_OFF));

  p_emerg_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (emerg_q && state != ST_SLEEP) |-> (div_k == K_SAFE));

  p_direct_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && wake_evt && mode_q == 2'b00 && rtc_on_main && !pend_q && !emerg_q)
    |=> (clk_sel == SEL_OSC));
endmodule

// File: tb/pll_clk_ctrl_tb.sv
module pll_clk_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic osc_lock_a = 1'b1, pll_lock_a = 1'b0;
  logic sleep_req = 1'b0, wake_evt = 1'b0, rtc_on_main = 1'b0;
  logic [4:0] div_k;
  logic vco_en, pll_locked, emerg, osc_locked, sleep_ok;
  logic [1:0] clk_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_clk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .osc_lock_a(osc_lock_a), .pll_lock_a(pll_lock_a), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .rtc_on_main(rtc_on_main), .div_k(div_k), .vco_en(vco_en),
    .clk_sel(clk_sel), .pll_locked(pll_locked), .emerg(emerg), .osc_locked(osc_locked),
    .sleep_ok(sleep_ok));

  string           req_q[$];
  logic [16:0]     exp_q[$];

  function automatic logic [5:0] mk(input logic [3:0] d, input logic [1:0] m);
    return {d, m};
  endfunction

  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        logic [16:0] act, e;
        string r;
        act = {div_k, pll_locked, emerg, vco_en, clk_sel, cfg_rdata, sleep_ok};
        e = exp_q.pop_front();
        r = req_q.pop_front();
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", r, act, e);
        end
      end
    end
  end

  task automatic chk(input string r, input logic [4:0] dk, input logic lk, input logic em,
                     input logic ve, input logic [1:0] sel, input logic [5:0] rd, input logic so);
    req_q.push_back(r);
    exp_q.push_back({dk, lk, em, ve, sel, rd, so});
    wait (exp_q.size() == 0);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] d);
    cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(3);
    chk("R1 reset", 5'd1, 0, 0, 0, 2'b00, mk(0, 0), 0);

    wr(mk(3, 2));
    chk("R2 relock start", 5'd16, 0, 0, 1, 2'b01, mk(4'hF, 2), 0);
    pll_lock_a = 1'b1; cyc(2);
    chk("R3 not yet after 2 edges", 5'd16, 0, 0, 1, 2'b01, mk(4'hF, 2), 0);
    cyc(1);
    chk("R3 lock on 3rd edge", 5'd4, 1, 0, 1, 2'b01, mk(3, 2), 1);

    wr(mk(5, 1));
    chk("R4 bypass vco on", 5'd6, 1, 0, 1, 2'b00, mk(5, 1), 1);
    wr(mk(7, 0));
    chk("R4 R6 bypass vco off", 5'd8, 1, 0, 0, 2'b00, mk(7, 0), 1);

    osc_lock_a = 1'b0; cyc(3);
    chk("R5 osc unlock", 5'd8, 1, 0, 0, 2'b00, mk(7, 0), 0);
    osc_lock_a = 1'b1; cyc(3);
    chk("R5 osc relock", 5'd8, 1, 0, 0, 2'b00, mk(7, 0), 1);

    rtc_on_main = 1'b1;
    pulse_sleep();
    chk("R6 R12 asleep", 5'd8, 1, 0, 0, 2'b10, mk(7, 0), 1);
    wr(mk(2, 2));
    chk("R11 write in sleep", 5'd8, 1, 0, 0, 2'b10, mk(7, 0), 1);
    osc_lock_a = 1'b0; cyc(3);
    pulse_wake();
    chk("R7 direct wake", 5'd8, 1, 0, 0, 2'b00, mk(7, 0), 0);
    osc_lock_a = 1'b1; cyc(3);

    rtc_on_main = 1'b0;
    pulse_sleep(); osc_lock_a = 1'b0; cyc(3);
    pulse_wake();
    chk("R8 wait osc", 5'd8, 1, 0, 0, 2'b10, mk(7, 0), 0);
    pulse_sleep();
    chk("R11 sleep in wake wait", 5'd8, 1, 0, 0, 2'b10, mk(7, 0), 0);
    osc_lock_a = 1'b1; cyc(2);
    chk("R8 still waiting", 5'd8, 1, 0, 0, 2'b10, mk(7, 0), 1);
    cyc(1);
    chk("R8 bypass resume", 5'd8, 1, 0, 0, 2'b00, mk(7, 0), 1);

    wr(mk(2, 2)); pll_lock_a = 1'b0; cyc(4); pll_lock_a = 1'b1; cyc(3);
    chk("R3 second lock", 5'd3, 1, 0, 1, 2'b01, mk(2, 2), 1);
    pulse_sleep(); pll_lock_a = 1'b0; osc_lock_a = 1'b0; cyc(3);
    pulse_wake();
    chk("R8 R6 pll wake wait", 5'd3, 1, 0, 0, 2'b10, mk(2, 2), 0);
    osc_lock_a = 1'b1; cyc(3);
    chk("R8 pll relock", 5'd16, 0, 0, 1, 2'b01, mk(4'hF, 2), 0);
    pll_lock_a = 1'b1; cyc(3);
    chk("R8 R12 pll resume", 5'd3, 1, 0, 1, 2'b01, mk(2, 2), 1);

    wr(mk(4, 3)); pll_lock_a = 1'b0;
    pulse_sleep(); cyc(2); pll_lock_a = 1'b1; cyc(3);
    pulse_wake();
    chk("R9 emergency", 5'd16, 0, 1, 1, 2'b01, mk(4'hF, 3), 0);
    cyc(10);
    chk("R9 emergency sticky", 5'd16, 0, 1, 1, 2'b01, mk(4'hF, 3), 0);
    wr(mk(0, 0));
    chk("R10 bypass ignored", 5'd16, 0, 1, 1, 2'b01, mk(4'hF, 3), 0);
    wr(mk(6, 2)); pll_lock_a = 1'b0; cyc(4);
    chk("R10 emerg during relock", 5'd16, 0, 1, 1, 2'b01, mk(4'hF, 2), 0);
    pll_lock_a = 1'b1; cyc(3);
    chk("R10 cleared by lock", 5'd7, 1, 0, 1, 2'b01, mk(6, 2), 1);

    wr(mk(4, 3)); pll_lock_a = 1'b0;
    pulse_sleep(); cyc(2);
    pulse_wake();
    chk("R9 emergency again", 5'd16, 0, 1, 1, 2'b01, mk(4'hF, 3), 0);
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(3);
    chk("R10 R1 reset clears", 5'd1, 0, 0, 0, 2'b00, mk(0, 0), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule